// File: doc/BRIEF.md
# Packed Vector Left Shifter

This block is the datapath for packed logical left shifts over a 256-bit vector. The vector is cut into lanes of 16, 32 or 64 bits. Every lane is shifted left by one shared count, and zeros fill the vacated low bits. The count comes from one of two places: a 64-bit count operand, or an 8-bit immediate.

The operating width is 64, 128 or 256 bits. Only the lanes inside that width are shifted. Above it, the result either carries the destination's previous contents or is cleared. Clearing applies only in 128-bit mode, and only when the clear flag is set.

Decode logic upstream presents one operation per cycle on `in_valid`. With the default configuration, the result appears one cycle later with `out_valid`. A count beyond the lane's top bit index clears every lane inside the operating width, instead of wrapping.

Top module: `vshl_unit`

## Requirements
- R1: Each lane is shifted left by the count and zeros fill its vacated low bits. No bit moves from one lane into a neighbouring lane.
- R2: `lane_sel` picks the lane size: 0 gives 16-bit lanes, 1 gives 32-bit lanes, and 2 or 3 give 64-bit lanes.
- R3: When the count is greater than the lane width minus one (15, 31 or 63), every result bit inside the operating width is zero.
- R4: In register form (`use_imm`=0), the count is the whole unsigned 64-bit `cnt_opnd`. Any set bit above the lane's index bits makes the count out of range, even when the low bits are small.
- R5: In immediate form (`use_imm`=1), the count is the unsigned 8-bit `cnt_imm`, and the out-of-range rule of R3 applies to it. In this form `cnt_opnd` has no effect.
- R6: When `width_sel`=1 (128 bits) and `zero_upper`=0, result bits 255:128 equal `dst_old` bits 255:128.
- R7: When `width_sel`=1 and `zero_upper`=1, result bits 255:128 are zero.
- R8: When `width_sel` is 2 or 3 (256 bits), all 256 bits are shifted with the single shared count.
- R9: When `width_sel`=0 (64 bits), only bits 63:0 are shifted and bits 255:64 equal `dst_old`. Outside 128-bit mode, `zero_upper` has no effect.
- R10: With `REG_OUT`=1, `out_valid` follows `in_valid` one cycle later. A cycle with `in_valid` low leaves `result` unchanged.
- R11: During reset, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| dst_old | input | 256 | Previous destination contents, used for the bits kept above the operating width |
| src_vec | input | 256 | Vector to be shifted |
| lane_sel | input | 2 | Lane size: 0 = 16, 1 = 32, 2/3 = 64 bits |
| width_sel | input | 2 | Operating width: 0 = 64, 1 = 128, 2/3 = 256 bits |
| zero_upper | input | 1 | In 128-bit mode, clear bits 255:128 instead of keeping them |
| use_imm | input | 1 | Take the count from `cnt_imm` instead of `cnt_opnd` |
| cnt_opnd | input | 64 | Count in register form |
| cnt_imm | input | 8 | Count in immediate form |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 256 | New destination value |

## Verification
Two things can land on the same operation. The out-of-range count clears the lanes inside the operating width. The width-mode merge decides what happens to the bits above it, either keeping `dst_old` or clearing them.

The sweep provokes this overlap on purpose. It pairs counts equal to the lane width, counts with high bits set, and immediate 255 with every width mode and both settings of `zero_upper`. Each result is judged bit by bit against a model in the bench. For every position, the model decides whether the bit is shifted source data, a forced zero, or carried from `dst_old`.

// File: rtl/vshl_pkg.sv
package vshl_pkg;
   // lane size select codes
   localparam logic [1:0] LSEL_16 = 2'd0;
   localparam logic [1:0] LSEL_32 = 2'd1;
   // operating width select codes
   localparam logic [1:0] WSEL_64  = 2'd0;
   localparam logic [1:0] WSEL_128 = 2'd1;

   // segments of SEG_W bits that the operating width covers
   function automatic int unsigned active_segs(input logic [1:0] wsel, input int unsigned nseg);
      case (wsel)
         WSEL_64:  return 1;
         WSEL_128: return 2;
         default:  return nseg;
      endcase
   endfunction
endpackage

// File: rtl/vshl_count.sv
module vshl_count #(
   parameter int CNT_W = 64,
   parameter int IMM_W = 8,
   parameter int SH_W  = 6
) (
   input  logic [CNT_W-1:0] cnt_opnd,
   input  logic [IMM_W-1:0] cnt_imm,
   input  logic             use_imm,
   input  logic [1:0]       lane_sel,
   output logic [SH_W-1:0]  shamt,
   output logic             over
);
   import vshl_pkg::*;

   logic [CNT_W-1:0] eff;

   always_comb begin
      eff = use_imm ? CNT_W'(cnt_imm) : cnt_opnd;
      shamt = eff[SH_W-1:0];
      // every count bit at or above the lane's index width counts
      case (lane_sel)
         LSEL_16: over = |eff[CNT_W-1:SH_W-2];
         LSEL_32: over = |eff[CNT_W-1:SH_W-1];
         default: over = |eff[CNT_W-1:SH_W];
      endcase
   end
endmodule

// File: rtl/vshl_lane_grp.sv
module vshl_lane_grp #(
   parameter int SEG_W  = 64,
   parameter int LANE_W = 16,
   localparam int LSH_W = $clog2(LANE_W),
   localparam int NLANE = SEG_W / LANE_W
) (
   input  logic [SEG_W-1:0] seg_in,
   input  logic [LSH_W-1:0] sh,
   output logic [SEG_W-1:0] seg_out
);
   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      assign seg_out[i*LANE_W +: LANE_W] = seg_in[i*LANE_W +: LANE_W] << sh;
   end
endmodule

// File: rtl/vshl_segment.sv
module vshl_segment #(
   parameter int SEG_W = 64,
   localparam int SH_W = $clog2(SEG_W)
) (
   input  logic [SEG_W-1:0] seg_in,
   input  logic [SH_W-1:0]  shamt,
   input  logic [1:0]       lane_sel,
   input  logic             over,
   output logic [SEG_W-1:0] seg_out
);
   import vshl_pkg::*;

   localparam int NGRP = 3;   // 16-, 32- and 64-bit lane variants

   logic [SEG_W-1:0] grp_out [NGRP];

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int LW = 16 << g;
      localparam int LS = $clog2(LW);
      vshl_lane_grp #(.SEG_W(SEG_W), .LANE_W(LW)) u_grp (
         .seg_in (seg_in),
         .sh     (shamt[LS-1:0]),
         .seg_out(grp_out[g])
      );
   end

   always_comb begin
      if (over)
         seg_out = '0;
      else begin
         case (lane_sel)
            LSEL_16: seg_out = grp_out[0];
            LSEL_32: seg_out = grp_out[1];
            default: seg_out = grp_out[2];
         endcase
      end
   end
endmodule

// File: rtl/vshl_merge.sv
module vshl_merge #(
   parameter int SEG_W   = 64,
   parameter int NUM_SEG = 4,
   localparam int VEC_W  = SEG_W * NUM_SEG
) (
   input  logic [VEC_W-1:0] shifted,
   input  logic [VEC_W-1:0] dst_old,
   input  logic [1:0]       width_sel,
   input  logic             zero_upper,
   output logic [VEC_W-1:0] merged
);
   import vshl_pkg::*;

   int unsigned nact;
   logic        clr_hi;

   assign nact   = active_segs(width_sel, NUM_SEG);
   assign clr_hi = (width_sel == WSEL_128) && zero_upper;

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      always_comb begin
         if (s < nact)
            merged[s*SEG_W +: SEG_W] = shifted[s*SEG_W +: SEG_W];
         else if (clr_hi)
            merged[s*SEG_W +: SEG_W] = '0;
         else
            merged[s*SEG_W +: SEG_W] = dst_old[s*SEG_W +: SEG_W];
      end
   end
endmodule

// File: rtl/vshl_unit.sv
module vshl_unit #(
   parameter int SEG_W   = 64,
   parameter int NUM_SEG = 4,
   parameter int CNT_W   = 64,
   parameter int IMM_W   = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int VEC_W  = SEG_W * NUM_SEG,
   localparam int SH_W   = $clog2(SEG_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] dst_old,
   input  logic [VEC_W-1:0] src_vec,
   input  logic [1:0]       lane_sel,
   input  logic [1:0]       width_sel,
   input  logic             zero_upper,
   input  logic             use_imm,
   input  logic [CNT_W-1:0] cnt_opnd,
   input  logic [IMM_W-1:0] cnt_imm,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   // elaboration-time parameter checks
   if (SEG_W != 64) begin : g_bad_seg
      $error("vshl_unit: SEG_W must be 64 (lane sizes 16/32/64)");
   end
   if (NUM_SEG < 2) begin : g_bad_nseg
      $error("vshl_unit: NUM_SEG must cover at least 128 bits");
   end
   if (IMM_W > CNT_W || CNT_W <= SH_W) begin : g_bad_cnt
      $error("vshl_unit: count widths inconsistent");
   end

   logic [SH_W-1:0]  shamt;
   logic             over;
   logic [VEC_W-1:0] shifted;
   logic [VEC_W-1:0] merged;

   vshl_count #(.CNT_W(CNT_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_count (
      .cnt_opnd(cnt_opnd),
      .cnt_imm (cnt_imm),
      .use_imm (use_imm),
      .lane_sel(lane_sel),
      .shamt   (shamt),
      .over    (over)
   );

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      vshl_segment #(.SEG_W(SEG_W)) u_seg (
         .seg_in  (src_vec[s*SEG_W +: SEG_W]),
         .shamt   (shamt),
         .lane_sel(lane_sel),
         .over    (over),
         .seg_out (shifted[s*SEG_W +: SEG_W])
      );
   end

   vshl_merge #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_merge (
      .shifted   (shifted),
      .dst_old   (dst_old),
      .width_sel (width_sel),
      .zero_upper(zero_upper),
      .merged    (merged)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) result <= merged;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = merged;
   end
endmodule

// File: rtl/vshl_chk.sv
module vshl_chk #(
   parameter int SEG_W   = 64,
   parameter int NUM_SEG = 4,
   parameter int CNT_W   = 64,
   parameter int IMM_W   = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int VEC_W  = SEG_W * NUM_SEG
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [VEC_W-1:0] dst_old,
   input logic [VEC_W-1:0] src_vec,
   input logic [1:0]       lane_sel,
   input logic [1:0]       width_sel,
   input logic             zero_upper,
   input logic             use_imm,
   input logic [CNT_W-1:0] cnt_opnd,
   input logic [IMM_W-1:0] cnt_imm,
   input logic             out_valid,
   input logic [VEC_W-1:0] result
);
   logic cnt_zero, imm16_over, w128, w256, w64;
   assign cnt_zero   = use_imm ? (cnt_imm == '0) : (cnt_opnd == '0);
   assign imm16_over = use_imm && (lane_sel == 2'd0) && (cnt_imm > IMM_W'(15));
   assign w64  = (width_sel == 2'd0);
   assign w128 = (width_sel == 2'd1);
   assign w256 = width_sel[1];

   if (REG_OUT) begin : g_seq
      // R10
      a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(result)));
      // R6
      a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && w128 && !zero_upper) |=>
            result[VEC_W-1:2*SEG_W] == $past(dst_old[VEC_W-1:2*SEG_W]));
      // R7
      a_r7_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && w128 && zero_upper) |=> result[VEC_W-1:2*SEG_W] == '0);
      // R9
      a_r9_narrow_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && w64) |=> result[VEC_W-1:SEG_W] == $past(dst_old[VEC_W-1:SEG_W]));
      // R8 / R1: zero count in full width returns the source untouched
      a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && w256 && cnt_zero) |=> result == $past(src_vec));
      // R3 / R5: oversized immediate on 16-bit lanes in full width
      a_r3_imm_over: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && w256 && imm16_over) |=> result == '0);
   end else begin : g_cmb
      a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
      a_r7_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         (w128 && zero_upper) |-> result[VEC_W-1:2*SEG_W] == '0);
      a_r9_narrow_pass: assert property (@(posedge clk) disable iff (!rst_n)
         w64 |-> result[VEC_W-1:SEG_W] == dst_old[VEC_W-1:SEG_W]);
      a_r3_imm_over: assert property (@(posedge clk) disable iff (!rst_n)
         (w256 && imm16_over) |-> result == '0);
   end
endmodule

bind vshl_unit vshl_chk #(
   .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .CNT_W(CNT_W), .IMM_W(IMM_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/test_vshl_unit.sv
`timescale 1ns/1ps
module test_vshl_unit;
   localparam int VW = 256;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [VW-1:0] dst_old, src_vec;
   logic [1:0]    lane_sel, width_sel;
   logic          zero_upper, use_imm;
   logic [63:0]   cnt_opnd;
   logic [7:0]    cnt_imm;
   logic          out_valid;
   logic [VW-1:0] result;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [63:0] seed = 64'h1234_5678_9abc_def1;

   always #2.5 clk = ~clk;

   vshl_unit i_vshl_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_old(dst_old),
      .src_vec(src_vec), .lane_sel(lane_sel), .width_sel(width_sel),
      .zero_upper(zero_upper), .use_imm(use_imm), .cnt_opnd(cnt_opnd),
      .cnt_imm(cnt_imm), .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] rnd64();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      return seed;
   endfunction

   // bitwise reference derived from the requirements
   function automatic logic [VW-1:0] model(
      input logic [VW-1:0] s, input logic [VW-1:0] d, input logic [1:0] ls,
      input logic [1:0] ws, input logic zu, input logic ui,
      input logic [63:0] c64, input logic [7:0] c8);
      logic [VW-1:0] r;
      int lw, nb;
      logic [63:0] c;
      lw = (ls == 2'd0) ? 16 : (ls == 2'd1) ? 32 : 64;
      nb = (ws == 2'd0) ? 64 : (ws == 2'd1) ? 128 : 256;
      c  = ui ? {56'd0, c8} : c64;
      for (int j = 0; j < VW; j++) begin
         if (j < nb) begin
            if (c < 64'(lw) && (j % lw) >= int'(c)) r[j] = s[j - int'(c)];
            else r[j] = 1'b0;
         end else if (ws == 2'd1 && zu) r[j] = 1'b0;
         else r[j] = d[j];
      end
      return r;
   endfunction

   task automatic chk_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%b exp=%b", tag, act, exp);
      end
   endtask

   // apply one operation at a falling edge, judge it one falling edge later
   task automatic run_op(input string tag, input logic [1:0] ls, input logic [1:0] ws,
                         input logic zu, input logic ui, input logic [63:0] c64,
                         input logic [7:0] c8);
      logic [VW-1:0] e;
      src_vec = {rnd64(), rnd64(), rnd64(), rnd64()};
      dst_old = {rnd64(), rnd64(), rnd64(), rnd64()};
      lane_sel = ls; width_sel = ws; zero_upper = zu; use_imm = ui;
      cnt_opnd = c64; cnt_imm = c8; in_valid = 1'b1;
      e = model(src_vec, dst_old, ls, ws, zu, ui, c64, c8);
      @(negedge clk);
      chk_vec(tag, result, e);
      chk_bit({tag, " R10 valid"}, out_valid, 1'b1);
   endtask

   initial begin
      #(5ns * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] hold;
      rst_n = 1'b0; in_valid = 1'b0; dst_old = '0; src_vec = '0;
      lane_sel = 2'd0; width_sel = 2'd0; zero_upper = 1'b0; use_imm = 1'b0;
      cnt_opnd = '0; cnt_imm = '0;
      repeat (3) @(negedge clk);
      // R11: reset values
      chk_vec("R11 result", result, '0);
      chk_bit("R11 valid", out_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: all-ones 16-bit lanes shifted by 4 give 0xfff0 per lane
      src_vec = {VW{1'b1}}; dst_old = '0; lane_sel = 2'd0; width_sel = 2'd2;
      zero_upper = 1'b0; use_imm = 1'b0; cnt_opnd = 64'd4; in_valid = 1'b1;
      @(negedge clk);
      chk_vec("R1 no crossing", result, {16{16'hfff0}});

      // R10: idle cycle keeps result and drops valid
      hold = result;
      in_valid = 1'b0; src_vec = '0; cnt_opnd = 64'd1;
      @(negedge clk);
      chk_vec("R10 hold", result, hold);
      chk_bit("R10 idle valid", out_valid, 1'b0);

      // R2: select code 3 behaves as 64-bit lanes
      run_op("R2 lane code 3", 2'd3, 2'd2, 1'b0, 1'b0, 64'd17, 8'd0);
      // R4: a high count bit clears 64-bit lanes despite small low bits
      run_op("R4 high bit", 2'd2, 2'd2, 1'b0, 1'b0, 64'h0000_0001_0000_0003, 8'd0);
      // R5: immediate wins over the register count
      run_op("R5 imm select", 2'd1, 2'd2, 1'b0, 1'b1, 64'hffff_ffff_ffff_ffff, 8'd7);
      // R9: clear flag ignored outside 128-bit mode
      run_op("R9 zu ignored", 2'd0, 2'd0, 1'b1, 1'b0, 64'd3, 8'd0);
      run_op("R8 zu ignored", 2'd0, 2'd3, 1'b1, 1'b0, 64'd3, 8'd0);

      // sweep: lane size x width mode x count class
      for (int l = 0; l < 3; l++) begin
         for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 10; k++) begin
               logic [1:0] ws;
               logic zu, ui, ov;
               logic [63:0] c64;
               logic [7:0] c8;
               int lw;
               string tag;
               lw = 16 << l;
               ws = (m == 0) ? 2'd0 : (m == 3) ? 2'd2 : 2'd1;
               zu = (m == 2);
               ui = (k >= 6);
               c8 = 8'd0; c64 = 64'd0;
               case (k)
                  0: c64 = 64'd0;
                  1: c64 = 64'd1;
                  2: c64 = 64'(lw - 1);
                  3: c64 = 64'(lw);
                  4: c64 = 64'h0000_0000_0000_0100 | 64'd2;
                  5: c64 = 64'h8000_0000_0000_0005;
                  6: c8 = 8'(lw - 1);
                  7: c8 = 8'(lw);
                  8: c8 = 8'd255;
                  default: c8 = 8'd3;
               endcase
               ov = ui ? (c8 >= 8'(lw)) : (c64 >= 64'(lw));
               if (ov) tag = ui ? "R3 R5 imm over" : "R3 R4 reg over";
               else if (m == 0) tag = "R9 w64";
               else if (m == 1) tag = "R6 w128 keep";
               else if (m == 2) tag = "R7 w128 clear";
               else tag = "R8 w256";
               run_op(tag, 2'(l), ws, zu, ui, c64, c8);
            end
         end
      end

      in_valid = 1'b0;
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule